// File: doc/BRIEF.md
# Register File with NIL-Detect Flags

This block is the register store of a list-processing datapath. It has two combinational read ports, D1 and D2, and one clocked write port. Each read port compares its word against NIL (the all-zero word) every cycle. It raises a flag on a match even when the port's output enable is low and the bus sees zero. Microcode can therefore branch on "register is NIL" without driving a value anywhere.

The write port chooses its data from one of three sources. The first is the result bus. The second is the NIL constant, which needs no ALU cycle. The third is the truth constant T or NIL, chosen by a condition code from the datapath, so that compare-style opcodes can finish without a branch to a NIL-setting step. Either read port can be forced to the program counter register. With the PC on D1 and an offset on D2, the ALU outside the block can form a backward jump target as D1 minus D2.

Top module: `lispRegFile`

## Requirements
- R1: While reset (`rstN` low) is applied and after it is released, every register holds NIL (all zeros). Both NIL flags read 1.
- R2: `rdData1`/`rdData2` show, combinationally, the register addressed by `rdAddr1`/`rdAddr2` when the port's enable `rdOe1`/`rdOe2` is 1.
- R3: `nilFlag1`/`nilFlag2` is 1 exactly when the register selected by that port equals zero.
- R4: With `wrEn`=1 and `wrSrc`=2'b00, the rising edge stores `resultBus` into register `wrAddr`.
- R5: With `wrEn`=1 and `wrSrc`=2'b01, the rising edge stores NIL into `wrAddr`, whatever `resultBus` carries.
- R6: With `wrEn`=1 and `wrSrc`=2'b10, the rising edge stores `TRUE_WORD` into `wrAddr` if `condCode`=1, and NIL if `condCode`=0.
- R7: `wrSrc`=2'b11 performs no write even with `wrEn`=1.
- R8: With `wrEn`=0, no register changes, whatever `wrSrc`, `resultBus` and `condCode` are.
- R9: A port that reads the address being written in the same cycle returns the old value. The new value appears after the clock edge.
- R10: `rdPc1`/`rdPc2`=1 makes that port read register `PC_INDEX` instead of its address input, on either port or on both at once.
- R11: With `rdPc1`=1 and the offset on D2, `rdData1 - rdData2` written back to `PC_INDEX` through the result bus gives the new PC.
- R12: With `rdOe1`/`rdOe2`=0, that port's data output is zero, while its NIL flag still reflects the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes on rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rdAddr1 | input | ADDR_W | D1 read address |
| rdPc1 | input | 1 | Force D1 to the PC register |
| rdOe1 | input | 1 | Drive D1 word onto rdData1 |
| rdData1 | output | DATA_W | D1 read data |
| nilFlag1 | output | 1 | D1 selected word is NIL |
| rdAddr2 | input | ADDR_W | D2 read address |
| rdPc2 | input | 1 | Force D2 to the PC register |
| rdOe2 | input | 1 | Drive D2 word onto rdData2 |
| rdData2 | output | DATA_W | D2 read data |
| nilFlag2 | output | 1 | D2 selected word is NIL |
| wrEn | input | 1 | Write enable |
| wrAddr | input | ADDR_W | Write address |
| wrSrc | input | 2 | 00 bus, 01 NIL, 10 T/NIL by condition, 11 none |
| condCode | input | 1 | Datapath condition for source 10 |
| resultBus | input | DATA_W | Datapath result to store |

## Verification
The bench builds the block with 16 registers, `PC_INDEX` = 15 and `TRUE_WORD` = 32'hA5A5_0001. The smaller array lets every register be written and read back in a short run. Placing the PC on the top address tests the override against the highest index. A non-trivial T word makes a condition write tell T apart from a plain bus value or a single set bit. With a 32-bit word, the backward-jump subtraction can be checked on real addresses.

// File: rtl/lispRegPkg.sv
package lispRegPkg;

  typedef enum logic [1:0] {
    SRC_BUS  = 2'b00,
    SRC_NIL  = 2'b01,
    SRC_COND = 2'b10,
    SRC_NONE = 2'b11
  } wrSrc_e;

  typedef struct packed {
    logic doWrite;
    logic selBus;
    logic selNil;
    logic selT;
  } wrStrobe_t;

endpackage

// File: rtl/regFileCtrl.sv
module regFileCtrl
  import lispRegPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrSrc,
  input  logic       condCode,
  output wrStrobe_t  strb
);

  wrSrc_e srcKind;

  always_comb begin
    srcKind = wrSrc_e'(wrSrc);
    strb    = '0;
    if (wrEn) begin
      unique case (srcKind)
        SRC_BUS:  begin strb.doWrite = 1'b1; strb.selBus = 1'b1; end
        SRC_NIL:  begin strb.doWrite = 1'b1; strb.selNil = 1'b1; end
        SRC_COND: begin
          strb.doWrite = 1'b1;
          strb.selT    = condCode;
          strb.selNil  = ~condCode;
        end
        default:  strb = '0;
      endcase
    end
  end

  // R6: at most one source is picked per cycle
  p_one_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.selBus, strb.selNil, strb.selT}));

  // R6: a write strobe always carries exactly one source
  p_write_has_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.doWrite |-> $countones({strb.selBus, strb.selNil, strb.selT}) == 1);

endmodule

// File: rtl/regReadPort.sv
module regReadPort #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  parameter int PC_INDEX = 31,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  input  logic [ADDR_W-1:0]               addr,
  input  logic                            usePc,
  input  logic                            oe,
  output logic [DATA_W-1:0]               dataOut,
  output logic                            nilFlag
);

  localparam logic [ADDR_W-1:0] PC_ADDR = ADDR_W'(PC_INDEX);

  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] word;

  always_comb begin
    selAddr = usePc ? PC_ADDR : addr;
    word    = '0;
    if ({1'b0, selAddr} < (ADDR_W+1)'(NUM_REGS))
      word = regs[selAddr];
    nilFlag = (word == '0);
    dataOut = oe ? word : '0;
  end

endmodule

// File: rtl/regFileData.sv
module regFileData
  import lispRegPkg::*;
#(
  parameter int            DATA_W    = 32,
  parameter int            NUM_REGS  = 32,
  parameter int            PC_INDEX  = 31,
  parameter logic [DATA_W-1:0] TRUE_WORD = 32'h0000_0004,
  localparam int           ADDR_W    = $clog2(NUM_REGS),
  localparam int           NUM_RD    = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  wrStrobe_t                     strb,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [DATA_W-1:0]             busIn,
  input  logic [NUM_RD-1:0][ADDR_W-1:0] rdAddr,
  input  logic [NUM_RD-1:0]             rdPc,
  input  logic [NUM_RD-1:0]             rdOe,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdData,
  output logic [NUM_RD-1:0]             nilFlag
);

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0]               wrWord;
  logic                            wrInRange;

  always_comb begin
    wrWord = '0;
    if (strb.selBus) wrWord = busIn;
    else if (strb.selT) wrWord = TRUE_WORD;
    wrInRange = ({1'b0, wrAddr} < (ADDR_W+1)'(NUM_REGS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regs <= '0;
    end else if (strb.doWrite && wrInRange) begin
      regs[wrAddr] <= wrWord;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    regReadPort #(
      .DATA_W  (DATA_W),
      .NUM_REGS(NUM_REGS),
      .PC_INDEX(PC_INDEX)
    ) u_port (
      .regs   (regs),
      .addr   (rdAddr[p]),
      .usePc  (rdPc[p]),
      .oe     (rdOe[p]),
      .dataOut(rdData[p]),
      .nilFlag(nilFlag[p])
    );
  end

  // R4: bus source lands in the addressed register
  p_bus_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doWrite && strb.selBus && wrInRange) |=> regs[$past(wrAddr)] == $past(busIn));

  // R5: NIL source clears the addressed register
  p_nil_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doWrite && strb.selNil && wrInRange) |=> regs[$past(wrAddr)] == '0);

  // R6: true condition stores the T word
  p_true_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doWrite && strb.selT && wrInRange) |=> regs[$past(wrAddr)] == TRUE_WORD);

  // R8: without a strobe the addressed register holds
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.doWrite |=> regs[$past(wrAddr)] == $past(regs[wrAddr]));

endmodule

// File: rtl/lispRegFile.sv
module lispRegFile
  import lispRegPkg::*;
#(
  parameter int            DATA_W    = 32,
  parameter int            NUM_REGS  = 32,
  parameter int            PC_INDEX  = 31,
  parameter logic [DATA_W-1:0] TRUE_WORD = 32'h0000_0004,
  localparam int           ADDR_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdAddr1,
  input  logic              rdPc1,
  input  logic              rdOe1,
  output logic [DATA_W-1:0] rdData1,
  output logic              nilFlag1,
  input  logic [ADDR_W-1:0] rdAddr2,
  input  logic              rdPc2,
  input  logic              rdOe2,
  output logic [DATA_W-1:0] rdData2,
  output logic              nilFlag2,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        wrSrc,
  input  logic              condCode,
  input  logic [DATA_W-1:0] resultBus
);

  wrStrobe_t                strb;
  logic [1:0][ADDR_W-1:0]   rdAddrV;
  logic [1:0][DATA_W-1:0]   rdDataV;
  logic [1:0]               nilV;

  assign rdAddrV  = {rdAddr2, rdAddr1};
  assign rdData1  = rdDataV[0];
  assign rdData2  = rdDataV[1];
  assign nilFlag1 = nilV[0];
  assign nilFlag2 = nilV[1];

  regFileCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrSrc   (wrSrc),
    .condCode(condCode),
    .strb    (strb)
  );

  regFileData #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .PC_INDEX (PC_INDEX),
    .TRUE_WORD(TRUE_WORD)
  ) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrAddr (wrAddr),
    .busIn  (resultBus),
    .rdAddr (rdAddrV),
    .rdPc   ({rdPc2, rdPc1}),
    .rdOe   ({rdOe2, rdOe1}),
    .rdData (rdDataV),
    .nilFlag(nilV)
  );

  // R7: the reserved source never raises a write strobe
  p_reserved_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSrc == 2'b11) |-> !strb.doWrite);

  // R3: an enabled port flags NIL exactly when it shows zero
  p_flag_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdOe1 |-> (nilFlag1 == (rdData1 == '0)));

  // R10: both ports forced to PC see the same word
  p_pc_both_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdPc1 && rdPc2 && rdOe1 && rdOe2) |-> (rdData1 == rdData2 && nilFlag1 == nilFlag2));

  // R12: a disabled port drives zero on its data output
  p_oe_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !rdOe2 |-> rdData2 == '0);

endmodule

// File: tb/lispRegFile_tb.sv
module lispRegFile_tb;

  localparam int          DW   = 32;
  localparam int          NR   = 16;
  localparam int          PCI  = 15;
  localparam logic [31:0] TW   = 32'hA5A5_0001;
  localparam int          AW   = $clog2(NR);

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] rdAddr1, rdAddr2, wrAddr;
  logic          rdPc1, rdPc2, rdOe1, rdOe2, wrEn, condCode;
  logic [1:0]    wrSrc;
  logic [DW-1:0] resultBus, rdData1, rdData2;
  logic          nilFlag1, nilFlag2;

  logic [DW-1:0] model [NR];
  int            nChecks = 0;
  int            nFails  = 0;
  bit            finished = 1'b0;

  always #4 clk = ~clk;

  lispRegFile #(.DATA_W(DW), .NUM_REGS(NR), .PC_INDEX(PCI), .TRUE_WORD(TW)) u_dut (
    .clk(clk), .rstN(rstN),
    .rdAddr1(rdAddr1), .rdPc1(rdPc1), .rdOe1(rdOe1), .rdData1(rdData1), .nilFlag1(nilFlag1),
    .rdAddr2(rdAddr2), .rdPc2(rdPc2), .rdOe2(rdOe2), .rdData2(rdData2), .nilFlag2(nilFlag2),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrSrc(wrSrc), .condCode(condCode), .resultBus(resultBus)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // Write through the port; model follows the requirement rules
  task automatic writeReg(input int a, input logic [1:0] src, input logic [DW-1:0] bus,
                          input logic cond, input logic en);
    @(negedge clk);
    wrEn = en; wrAddr = AW'(a); wrSrc = src; resultBus = bus; condCode = cond;
    @(negedge clk);
    wrEn = 1'b0;
    if (en) begin
      case (src)
        2'b00: model[a] = bus;
        2'b01: model[a] = '0;
        2'b10: model[a] = cond ? TW : '0;
        default: ;
      endcase
    end
  endtask

  task automatic readBoth(input int a1, input int a2);
    rdPc1 = 1'b0; rdPc2 = 1'b0; rdOe1 = 1'b1; rdOe2 = 1'b1;
    rdAddr1 = AW'(a1); rdAddr2 = AW'(a2);
    #1;
  endtask

  task automatic tReset();
    for (int i = 0; i < NR; i++) begin
      readBoth(i, NR - 1 - i);
      check("R1 reset d1", rdData1, '0);
      check("R1 reset d2", rdData2, '0);
      check("R1 flag1", {31'b0, nilFlag1}, 32'd1);
    end
  endtask

  task automatic tBusWrite();
    writeReg(2, 2'b00, 32'h1234_5678, 1'b0, 1'b1);
    writeReg(7, 2'b00, 32'h0000_0001, 1'b1, 1'b1);
    readBoth(2, 7);
    check("R4 bus d1", rdData1, model[2]);
    check("R2 read d2", rdData2, model[7]);
    check("R3 flag1 nonnil", {31'b0, nilFlag1}, 32'd0);
    check("R3 flag2 nonnil", {31'b0, nilFlag2}, 32'd0);
  endtask

  task automatic tNilWrite();
    writeReg(2, 2'b01, 32'hFFFF_FFFF, 1'b1, 1'b1);
    readBoth(2, 7);
    check("R5 nil write", rdData1, '0);
    check("R3 flag1 nil", {31'b0, nilFlag1}, 32'd1);
    check("R5 neighbour kept", rdData2, 32'h0000_0001);
  endtask

  task automatic tCondWrite();
    writeReg(4, 2'b10, 32'h0BAD_0BAD, 1'b1, 1'b1);
    writeReg(5, 2'b00, 32'h0000_0099, 1'b0, 1'b1);
    writeReg(5, 2'b10, 32'h0BAD_0BAD, 1'b0, 1'b1);
    readBoth(4, 5);
    check("R6 cond true", rdData1, TW);
    check("R6 cond false", rdData2, '0);
    check("R6 flag2 nil", {31'b0, nilFlag2}, 32'd1);
  endtask

  task automatic tNoWrite();
    writeReg(4, 2'b11, 32'h7777_7777, 1'b1, 1'b1);
    writeReg(7, 2'b00, 32'h6666_6666, 1'b1, 1'b0);
    writeReg(7, 2'b01, 32'h0, 1'b0, 1'b0);
    readBoth(4, 7);
    check("R7 reserved src", rdData1, TW);
    check("R8 wrEn low", rdData2, 32'h0000_0001);
  endtask

  task automatic tSameCycle();
    readBoth(9, 9);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(9); wrSrc = 2'b00; resultBus = 32'hCAFE_F00D;
    #1;
    check("R9 old value d1", rdData1, '0);
    check("R9 old flag", {31'b0, nilFlag2}, 32'd1);
    @(negedge clk);
    wrEn = 1'b0; model[9] = 32'hCAFE_F00D;
    #1;
    check("R9 new value", rdData2, 32'hCAFE_F00D);
  endtask

  task automatic tPcSelect();
    writeReg(PCI, 2'b00, 32'h0000_0100, 1'b0, 1'b1);
    readBoth(3, 3);
    rdPc2 = 1'b1; #1;
    check("R10 pc on d2", rdData2, 32'h0000_0100);
    check("R10 d1 unaffected", rdData1, '0);
    rdPc1 = 1'b1; #1;
    check("R10 pc on d1", rdData1, 32'h0000_0100);
  endtask

  task automatic tNegJump();
    logic [DW-1:0] target;
    writeReg(3, 2'b00, 32'h0000_0024, 1'b0, 1'b1);
    readBoth(3, 3);
    rdPc1 = 1'b1; #1;
    target = 32'h0000_0100 - 32'h0000_0024;
    check("R11 d1 pc", rdData1, 32'h0000_0100);
    check("R11 d2 offset", rdData2, 32'h0000_0024);
    writeReg(PCI, 2'b00, rdData1 - rdData2, 1'b0, 1'b1);
    readBoth(0, 0);
    rdPc2 = 1'b1; #1;
    check("R11 new pc", rdData2, target);
  endtask

  task automatic tOutEnable();
    readBoth(9, 4);
    rdOe1 = 1'b0; rdOe2 = 1'b0; #1;
    check("R12 d1 quiet", rdData1, '0);
    check("R12 flag1 nonnil", {31'b0, nilFlag1}, 32'd0);
    rdAddr2 = AW'(5); #1;
    check("R12 d2 quiet", rdData2, '0);
    check("R12 flag2 nil", {31'b0, nilFlag2}, 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrSrc = 2'b00; condCode = 1'b0;
    resultBus = '0; rdAddr1 = '0; rdAddr2 = '0; rdPc1 = 1'b0; rdPc2 = 1'b0;
    rdOe1 = 1'b1; rdOe2 = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tBusWrite();
    tNilWrite();
    tCondWrite();
    tNoWrite();
    tSameCycle();
    tPcSelect();
    tNegJump();
    tOutEnable();
    repeat (2) @(negedge clk);
    summary();
  end

endmodule